// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits beside an SDRAM command sequencer and turns a programmed 10-bit mode word into the column addresses for one read or write burst. When the sequencer issues the mode-register-set cycle, it pulses `mode_ld` with the address-bus value. The block decodes and holds four settings from that value: the burst length, the wrap ordering, the CAS latency and the write-burst policy. The CAS latency and the write policy are also presented as outputs for the sequencer to use.

Each `burst_go` pulse carries a 9-bit starting column and a read/write flag. From the next cycle on, the block emits one column per cycle, with `col_vld` high. It raises `col_last` on the final beat of a fixed-length burst and then goes idle. Sequential bursts increment within an aligned block of the burst length. Interleaved bursts XOR the beat number into the start column. A full-page burst walks all 512 columns with wrap-around until `burst_stop` ends it.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After synchronous reset, `col_vld`, `col_last`, `cas_lat` and `wr_single` are all 0, and no mode word counts as loaded.
- R2: A `burst_go` pulse is ignored, and `col_vld` stays 0, until at least one mode word has been loaded.
- R3: One cycle after a `mode_ld` pulse, `cas_lat` equals mode bits [6:4] and `wr_single` equals mode bit 9. Both hold their value while no load occurs.
- R4: Mode bits [2:0] select the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives full page. The unused codes 100, 101 and 110 give 1 beat. Beat 0 (the start column) appears the cycle after `burst_go`, and each following beat appears one cycle later.
- R5: With mode bit 3 = 0 (sequential), beat k of an N-beat burst keeps the column bits above the low log2(N) bits and sets the low bits to (start + k) mod N.
- R6: With mode bit 3 = 1 (interleaved), beat k of an N-beat burst is the start column XOR k.
- R7: A full-page burst advances by one column per cycle, wraps from 511 to 0, never raises `col_last`, and runs until `burst_stop`.
- R8: A full-page length combined with interleave is forced to sequential ordering.
- R9: `col_last` is high only together with `col_vld`, and only on the final beat of a fixed-length burst. `col_vld` is low the cycle after that beat unless a new burst starts.
- R10: `burst_stop` during an active burst makes `col_vld` low in the next cycle. A `burst_go` in the same cycle takes priority and starts a new burst.
- R11: When `wr_single` is 1, a write burst (`burst_wr` = 1) lasts exactly one beat. Read bursts, and writes with `wr_single` = 0, use the programmed length.
- R12: A `burst_go` during an active burst restarts at the new column. A mode load during a burst does not change the burst in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_ld | input | 1 | Mode-register-set strobe |
| mode_val | input | 10 | Mode word taken from address bits 0..9 |
| burst_go | input | 1 | Burst start strobe |
| burst_col | input | 9 | Starting column of the burst |
| burst_wr | input | 1 | 1 when the burst being started is a write |
| burst_stop | input | 1 | Burst terminate |
| col | output | 9 | Current column address |
| col_vld | output | 1 | A column beat is presented this cycle |
| col_last | output | 1 | Final beat of a fixed-length burst |
| cas_lat | output | 3 | Decoded CAS latency field |
| wr_single | output | 1 | Write-burst policy: 1 = single-beat writes |

## Verification
The bench targets start columns that are not aligned to the burst length. A design that carries into the upper bits on a sequential wrap, or that adds instead of XORing on interleave, produces wrong columns there. A full-page run is started at column 510 so that it crosses the 511-to-0 wrap. It continues past 512 beats, which exposes a design that stops early or asserts `col_last`. Further directed cases cover the reserved length codes, full page combined with interleave, a stop and a start in the same cycle, restarts and mode loads mid-burst, and single-beat writes versus reads. Each of these shows a wrong beat count or wrong column when the matching rule is broken. Random traffic then mixes all of these cases against a bench model.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    localparam int COL_W   = 9;
    localparam int MODE_W  = 10;
    localparam int CAS_W   = 3;
    localparam int LEN_W   = 3;
    localparam int CAS_LSB = 4;
    localparam int ORD_BIT = 3;
    localparam int WRS_BIT = 9;
    localparam logic [LEN_W-1:0] LEN_PAGE_CODE = 3'b111;
    localparam int LEN_MAX_POW = 3;

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } order_e;

    typedef struct packed {
        logic [COL_W-1:0] mask;
        logic             page;
        order_e           order;
        logic [CAS_W-1:0] cas;
        logic             wr_single;
    } mode_cfg_t;

    typedef struct packed {
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] mask;
        logic             page;
        order_e           order;
    } burst_t;

    function automatic logic [COL_W-1:0] len_mask(input logic [LEN_W-1:0] code);
        logic [COL_W-1:0] m;
        m = '0;
        if (code == LEN_PAGE_CODE) begin
            m = '1;
        end else if (int'(code) <= LEN_MAX_POW) begin
            for (int b = 0; b < LEN_MAX_POW; b++) begin
                if (b < int'(code)) m[b] = 1'b1;
            end
        end
        return m;
    endfunction

    function automatic mode_cfg_t decode_mode(input logic [MODE_W-1:0] w);
        mode_cfg_t c;
        logic [LEN_W-1:0] code;
        code        = w[LEN_W-1:0];
        c.mask      = len_mask(code);
        c.page      = (code == LEN_PAGE_CODE);
        c.order     = (w[ORD_BIT] && !c.page) ? ORD_INTLV : ORD_SEQ;
        c.cas       = w[CAS_LSB +: CAS_W];
        c.wr_single = w[WRS_BIT];
        return c;
    endfunction

    function automatic logic [COL_W-1:0] beat_col(
        input logic [COL_W-1:0] base,
        input logic [COL_W-1:0] idx,
        input logic [COL_W-1:0] mask,
        input order_e           order
    );
        logic [COL_W-1:0] sum;
        sum = base + idx;
        if (order == ORD_INTLV) begin
            return base ^ (idx & mask);
        end
        return (base & ~mask) | (sum & mask);
    endfunction

endpackage

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg
    import colgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [MODE_W-1:0] word,
    output mode_cfg_t         cfg,
    output logic              loaded
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            loaded <= 1'b0;
        end else if (ld) begin
            cfg    <= decode_mode(word);
            loaded <= 1'b1;
        end
    end

endmodule

// File: rtl/colgen_beat_ctrl.sv
module colgen_beat_ctrl
    import colgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [COL_W-1:0] go_col,
    input  logic             go_wr,
    input  logic             stop,
    input  mode_cfg_t        cfg,
    input  logic             loaded,
    output logic             active,
    output logic             last,
    output logic [COL_W-1:0] idx,
    output burst_t           cur
);

    burst_t nxt;
    logic   one_beat;

    always_comb begin
        one_beat   = go_wr && cfg.wr_single;
        nxt.base   = go_col;
        nxt.mask   = one_beat ? '0 : cfg.mask;
        nxt.page   = one_beat ? 1'b0 : cfg.page;
        nxt.order  = cfg.order;
    end

    assign last = active && !cur.page && (idx == cur.mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            cur    <= '0;
        end else if (go && loaded) begin
            active <= 1'b1;
            idx    <= '0;
            cur    <= nxt;
        end else if (active) begin
            if (stop || last) begin
                active <= 1'b0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map
    import colgen_pkg::*;
(
    input  burst_t           cur,
    input  logic [COL_W-1:0] idx,
    output logic [COL_W-1:0] col
);

    always_comb begin
        col = beat_col(cur.base, idx, cur.mask, cur.order);
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import colgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_ld,
    input  logic [MODE_W-1:0] mode_val,
    input  logic              burst_go,
    input  logic [COL_W-1:0]  burst_col,
    input  logic              burst_wr,
    input  logic              burst_stop,
    output logic [COL_W-1:0]  col,
    output logic              col_vld,
    output logic              col_last,
    output logic [CAS_W-1:0]  cas_lat,
    output logic              wr_single
);

    mode_cfg_t        cfg;
    logic             mode_ok;
    logic [COL_W-1:0] beat_idx;
    burst_t           cur;

    colgen_mode_reg u_mode (
        .clk    (clk),
        .rst    (rst),
        .ld     (mode_ld),
        .word   (mode_val),
        .cfg    (cfg),
        .loaded (mode_ok)
    );

    colgen_beat_ctrl u_beat (
        .clk    (clk),
        .rst    (rst),
        .go     (burst_go),
        .go_col (burst_col),
        .go_wr  (burst_wr),
        .stop   (burst_stop),
        .cfg    (cfg),
        .loaded (mode_ok),
        .active (col_vld),
        .last   (col_last),
        .idx    (beat_idx),
        .cur    (cur)
    );

    colgen_addr_map u_map (
        .cur (cur),
        .idx (beat_idx),
        .col (col)
    );

    assign cas_lat   = cfg.cas;
    assign wr_single = cfg.wr_single;

endmodule

// File: rtl/colgen_chk.sv
module colgen_chk
    import colgen_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             mode_ld,
    input logic             burst_go,
    input logic [COL_W-1:0] burst_col,
    input logic             burst_wr,
    input logic             burst_stop,
    input logic [COL_W-1:0] col,
    input logic             col_vld,
    input logic             col_last,
    input logic [CAS_W-1:0] cas_lat,
    input logic             wr_single,
    input logic             loaded
);

    assert_unloaded_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !loaded |-> !col_vld);

    assert_mode_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !mode_ld |=> ($stable(cas_lat) && $stable(wr_single)));

    assert_first_beat_R4: assert property (@(posedge clk) disable iff (rst)
        (burst_go && loaded) |=> (col_vld && col == $past(burst_col)));

    assert_continue_R4: assert property (@(posedge clk) disable iff (rst)
        (col_vld && !col_last && !burst_stop) |=> col_vld);

    assert_last_valid_R9: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_vld);

    assert_end_after_last_R9: assert property (@(posedge clk) disable iff (rst)
        (col_last && !burst_go) |=> !col_vld);

    assert_stop_ends_R10: assert property (@(posedge clk) disable iff (rst)
        (col_vld && burst_stop && !burst_go) |=> !col_vld);

    assert_single_write_R11: assert property (@(posedge clk) disable iff (rst)
        (burst_go && loaded && burst_wr && wr_single) |=> col_last);

endmodule

bind sdram_burst_colgen colgen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_ld    (mode_ld),
    .burst_go   (burst_go),
    .burst_col  (burst_col),
    .burst_wr   (burst_wr),
    .burst_stop (burst_stop),
    .col        (col),
    .col_vld    (col_vld),
    .col_last   (col_last),
    .cas_lat    (cas_lat),
    .wr_single  (wr_single),
    .loaded     (mode_ok)
);

// File: tb/sim_sdram_burst_colgen.sv
module sim_sdram_burst_colgen;
    import colgen_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mode_ld = 1'b0;
    logic [9:0]       mode_val = '0;
    logic             burst_go = 1'b0;
    logic [8:0]       burst_col = '0;
    logic             burst_wr = 1'b0;
    logic             burst_stop = 1'b0;
    logic [8:0]       col;
    logic             col_vld, col_last, wr_single;
    logic [2:0]       cas_lat;

    int n_chk = 0;
    int n_fail = 0;
    string tag = "R1";

    // bench model state
    bit m_ld, m_inter, m_wrs, m_active, m_binter;
    int m_len, m_blen, m_idx, m_base, m_cas;

    sdram_burst_colgen u0 (
        .clk(clk), .rst(rst), .mode_ld(mode_ld), .mode_val(mode_val),
        .burst_go(burst_go), .burst_col(burst_col), .burst_wr(burst_wr),
        .burst_stop(burst_stop), .col(col), .col_vld(col_vld),
        .col_last(col_last), .cas_lat(cas_lat), .wr_single(wr_single)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int len_of(int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic logic [9:0] mk_mode(int code, int inter, int cas, int wrs);
        return {wrs[0], 2'b00, cas[2:0], inter[0], code[2:0]};
    endfunction

    function automatic int exp_col();
        int mask;
        mask = (m_blen == 0) ? 511 : m_blen - 1;
        if (m_binter) return m_base ^ m_idx;
        return (m_base & ~mask & 511) | ((m_base + m_idx) & mask);
    endfunction

    task automatic chk(string t, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
        end
    endtask

    task automatic model_update();
        if (rst) begin
            m_ld = 0; m_active = 0; m_idx = 0; m_cas = 0; m_wrs = 0;
            m_len = 1; m_inter = 0; m_blen = 1; m_binter = 0; m_base = 0;
        end else begin
            if (burst_go && m_ld) begin
                m_active = 1; m_idx = 0; m_base = int'(burst_col);
                m_blen = (burst_wr && m_wrs) ? 1 : m_len;
                m_binter = m_inter;
            end else if (m_active) begin
                if (burst_stop || (m_blen != 0 && m_idx == m_blen - 1)) m_active = 0;
                else m_idx = (m_idx + 1) % 512;
            end
            if (mode_ld) begin
                m_len = len_of(int'(mode_val[2:0]));
                m_inter = (m_len == 0) ? 1'b0 : mode_val[3];
                m_cas = int'(mode_val[6:4]);
                m_wrs = mode_val[9];
                m_ld = 1;
            end
        end
    endtask

    task automatic check_all();
        chk(tag, "col_vld", int'(col_vld), int'(m_active));
        if (m_active) begin
            chk(tag, "col", int'(col), exp_col());
            chk(tag, "col_last", int'(col_last),
                int'(m_blen != 0 && m_idx == m_blen - 1));
        end else begin
            chk(tag, "col_last idle", int'(col_last), 0);
        end
        chk(tag, "cas_lat", int'(cas_lat), m_cas);
        chk(tag, "wr_single", int'(wr_single), int'(m_wrs));
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check_all();
    endtask

    task automatic load(logic [9:0] w);
        mode_ld = 1'b1; mode_val = w;
        tick();
        mode_ld = 1'b0;
    endtask

    task automatic go(int c, bit wr);
        burst_go = 1'b1; burst_col = c[8:0]; burst_wr = wr;
        tick();
        burst_go = 1'b0; burst_wr = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1C0DE5));
        // R1 reset state
        tag = "R1";
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        tick();
        chk("R1", "reset col_vld", int'(col_vld), 0);

        // R2 start before any mode load
        tag = "R2";
        go(37, 1'b0);
        chk("R2", "unloaded start", int'(col_vld), 0);
        idle(2);

        // R3 mode load: seq, 8 beats, cas 3, burst writes
        tag = "R3";
        load(mk_mode(3, 0, 3, 0));
        chk("R3", "cas_lat", int'(cas_lat), 3);
        chk("R3", "wr_single", int'(wr_single), 0);

        // R5 sequential 8-beat from 0xD5
        tag = "R5";
        go(213, 1'b0);
        chk("R5", "beat0", int'(col), 213);
        idle(3);
        chk("R5", "beat3 wraps low bits", int'(col), 208);
        idle(4);
        chk("R9", "last beat flag", int'(col_last), 1);
        tag = "R9";
        tick();
        chk("R9", "idle after last", int'(col_vld), 0);

        // R6 interleave 4 beats from 0x1A6
        tag = "R6";
        load(mk_mode(2, 1, 2, 0));
        go(422, 1'b0);
        chk("R6", "beat0", int'(col), 422);
        tick();
        chk("R6", "beat1", int'(col), 423);
        tick();
        chk("R6", "beat2", int'(col), 420);
        tick();
        chk("R6", "beat3", int'(col), 421);
        idle(2);

        // R7 full page from 510 across wrap, long run, then stop (R10)
        tag = "R7";
        load(mk_mode(7, 0, 3, 0));
        go(510, 1'b0);
        idle(2);
        chk("R7", "wrapped to 0", int'(col), 0);
        idle(600);
        chk("R7", "still running", int'(col_vld), 1);
        tag = "R10";
        burst_stop = 1'b1; tick(); burst_stop = 1'b0;
        chk("R10", "stopped", int'(col_vld), 0);
        idle(2);

        // R8 full page with interleave forced to sequential
        tag = "R8";
        load(mk_mode(7, 1, 2, 0));
        go(5, 1'b0);
        idle(3);
        chk("R8", "sequential beat3", int'(col), 8);
        burst_stop = 1'b1; tick(); burst_stop = 1'b0;

        // R4 reserved length code gives one beat
        tag = "R4";
        load(mk_mode(5, 0, 2, 0));
        go(100, 1'b0);
        chk("R4", "reserved one beat last", int'(col_last), 1);
        tick();
        chk("R4", "reserved idle", int'(col_vld), 0);
        load(mk_mode(1, 0, 2, 0));
        go(101, 1'b0);
        tick();
        chk("R4", "two-beat wrap", int'(col), 100);
        idle(2);

        // R11 single write policy
        tag = "R11";
        load(mk_mode(3, 0, 2, 1));
        chk("R11", "wr_single out", int'(wr_single), 1);
        go(64, 1'b1);
        chk("R11", "write single beat", int'(col_last), 1);
        tick();
        go(64, 1'b0);
        idle(7);
        chk("R11", "read keeps length", int'(col_last), 1);
        tick();

        // R12 restart and mode load mid-burst
        tag = "R12";
        load(mk_mode(3, 0, 2, 0));
        go(16, 1'b0);
        idle(2);
        go(300, 1'b0);
        chk("R12", "restart column", int'(col), 300);
        load(mk_mode(1, 1, 3, 0));
        idle(6);
        chk("R12", "old length kept", int'(col_last), 1);
        tick();

        // R10 stop and start in the same cycle
        tag = "R10";
        go(40, 1'b0);
        tick();
        burst_stop = 1'b1;
        go(77, 1'b0);
        burst_stop = 1'b0;
        chk("R10", "start wins", int'(col), 77);
        idle(3);

        // random mix: R4/R5/R6/R9/R11/R12
        tag = "random R4/R5/R6/R9";
        for (int i = 0; i < 3000; i++) begin
            mode_ld    = ($urandom % 25) == 0;
            mode_val   = 10'($urandom);
            burst_go   = ($urandom % 7) == 0;
            burst_col  = 9'($urandom);
            burst_wr   = 1'($urandom);
            burst_stop = ($urandom % 20) == 0;
            tick();
        end
        mode_ld = 1'b0; burst_go = 1'b0; burst_stop = 1'b0; burst_wr = 1'b0;
        idle(2);
        finish_run();
    end

endmodule